// File: doc/BRIEF.md
# Direction-Masked General-Purpose I/O Port

This block is an eight-signal general-purpose I/O port on a simple CPU register bus. Each signal is set separately as an input or an output, so the port can hold any mix of the two. Software reaches the port through two registers: a direction register and a data register. A one-bit address picks between them. A single-cycle write strobe loads the selected register, and a read strobe captures its contents into a registered read port.

Each pad gets an output value and an output enable, and the port samples each pad's input level. A write to the data register changes only the bits currently set as outputs. A read of the data register returns a per-bit mix. Output bits show the value latched for them, which is also the level being driven. Input bits show the pin level after a two-flop synchroniser. The port has no interrupt or change detection, so software polls the data register to see changes on input pins.

Top module: `pio_port`

## Requirements
- R1: While reset is asserted (rst_n low), every direction bit is 0 (input), every latched data bit is 0, and both pad_oe and pad_out read 8'h00. rdata also reads 8'h00.
- R2: A write with addr=0 loads wdata into the direction register on that clock edge. A later read with addr=0 returns exactly the value written.
- R3: pad_oe bit i equals direction bit i (1 = output), and pad_out bit i equals latched data bit i.
- R4: A write with addr=1 loads wdata only into the data bits whose direction bit is 1. Data bits whose direction bit is 0 keep their previous latched value.
- R5: A write to the direction register leaves every latched data bit unchanged.
- R6: A read with addr=1 returns the synchronised pin level for bits whose direction bit is 0. A pin change made before clock edge k is first seen by a read strobe sampled at edge k+2.
- R7: A read with addr=1 returns the latched data value for bits whose direction bit is 1, whatever the pin levels are.
- R8: rdata is loaded only on a clock edge where rd_en is 1, one cycle after the strobe is driven. Otherwise rdata holds its value.
- R9: When rd_en and wr_en are both asserted in the same cycle, rdata returns the register contents from before that write.
- R10: With wr_en low, the values on addr and wdata change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register select: 0 direction, 1 data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
A register write and a register read can land on the same clock edge. The interesting case is a data write together with a data read, or a direction write together with a data read. The bench drives both strobes in one cycle on data that differs from the value being written. It checks that rdata shows the old contents, and that a read in the next cycle shows the new contents. Pin changes that arrive just before a read are also timed on purpose. This shows that a read issued one edge too early still returns the old level, and a read one edge later returns the new one.

// File: rtl/pio_pkg.sv
package pio_pkg;
    parameter int PIO_WIDTH = 8;
    parameter int SYNC_STAGES = 2;

    typedef enum logic {
        REG_DIR  = 1'b0,
        REG_DATA = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] data_q
);
    logic [WIDTH-1:0] dir_d;
    logic [WIDTH-1:0] data_d;

    always_comb begin
        dir_d  = dir_q;
        data_d = data_q;
        if (wr_en) begin
            unique case (sel)
                REG_DIR:  dir_d  = wdata;
                REG_DATA: data_d = (wdata & dir_q) | (data_q & ~dir_q);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
        end else begin
            dir_q  <= dir_d;
            data_q <= data_d;
        end
    end
endmodule

// File: rtl/pio_readback.sv
module pio_readback
    import pio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mixed;
    logic [WIDTH-1:0] rd_next;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign mixed[b] = dir_q[b] ? data_q[b] : pin_sync[b];
        end
    endgenerate

    always_comb begin
        unique case (sel)
            REG_DIR:  rd_next = dir_q;
            REG_DATA: rd_next = mixed;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int WIDTH  = PIO_WIDTH,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] pin_sync;

    assign sel = reg_sel_e'(addr);

    pio_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    pio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (wdata),
        .dir_q  (dir_q),
        .data_q (data_q)
    );

    pio_readback #(.WIDTH(WIDTH)) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (sel),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .pin_sync (pin_sync),
        .rdata    (rdata)
    );

    assign pad_oe  = dir_q;
    assign pad_out = data_q;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             addr,
    input logic [WIDTH-1:0] wdata,
    input logic [WIDTH-1:0] rdata,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe
);
    // R1: reset state seen at every edge while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (pad_oe == '0 && pad_out == '0 && rdata == '0);
        end
    end

    // R2 / R3: direction write drives the output enables
    a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> (pad_oe == $past(wdata)));

    // R4: data write is masked by direction
    a_r4_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr) |=> (pad_out == (($past(wdata) & $past(pad_oe)) |
                                         ($past(pad_out) & ~$past(pad_oe)))));

    // R5: direction write leaves the data latch alone
    a_r5_dir_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> $stable(pad_out));

    // R7: output bits read back the latched value
    a_r7_out_bits_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr && !wr_en) |=>
            ((rdata & $past(pad_oe)) == ($past(pad_out) & $past(pad_oe))));

    // R8: rdata holds without a read strobe
    a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R10: no write strobe, no register change
    a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind pio_port pio_port_chk #(.WIDTH(WIDTH)) chk (.*);

// File: tb/pio_port_test.sv
module pio_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pio_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe)
    );

    // {dir, wdata, pins, expected data read, expected pad_out}
    localparam logic [39:0] VEC [5] = '{
        {8'h00, 8'hFF, 8'hA5, 8'hA5, 8'h00},
        {8'hFF, 8'h3C, 8'h00, 8'h3C, 8'h3C},
        {8'hF0, 8'hAB, 8'h0F, 8'hAF, 8'hA0},
        {8'h5A, 8'hFF, 8'h81, 8'hDB, 8'h5A},
        {8'h0F, 8'h96, 8'hC3, 8'hC6, 8'h06}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus(input logic wr, input logic rd, input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        do_reset();

        // Table walk: R3 R4 R6 R7
        for (int i = 0; i < 5; i++) begin
            do_reset();
            pad_in = VEC[i][23:16];
            bus(1'b1, 1'b0, 1'b0, VEC[i][39:32]);
            bus(1'b1, 1'b0, 1'b1, VEC[i][31:24]);
            repeat (2) @(negedge clk);
            bus(1'b0, 1'b1, 1'b1, 8'h00);
            check("R6/R7 mixed read", rdata, VEC[i][15:8]);
            check("R3 pad_oe", pad_oe, VEC[i][39:32]);
            check("R4 pad_out", pad_out, VEC[i][7:0]);
        end

        // R2 direction read-back
        do_reset();
        bus(1'b1, 1'b0, 1'b0, 8'h6C);
        bus(1'b0, 1'b1, 1'b0, 8'h00);
        check("R2 dir readback", rdata, 8'h6C);

        // R4 retention on input bits, R5 dir write keeps data
        bus(1'b1, 1'b0, 1'b0, 8'hFF);
        bus(1'b1, 1'b0, 1'b1, 8'hAA);
        bus(1'b1, 1'b0, 1'b0, 8'h0F);
        bus(1'b1, 1'b0, 1'b1, 8'h55);
        check("R4 masked latch", pad_out, 8'hA5);
        bus(1'b1, 1'b0, 1'b0, 8'hFF);
        check("R5 dir write keeps data", pad_out, 8'hA5);
        pad_in = 8'h00;
        bus(1'b0, 1'b1, 1'b1, 8'h00);
        check("R7 output bits ignore pins", rdata, 8'hA5);

        // R10 no write without strobe
        bus(1'b0, 1'b0, 1'b1, 8'h00);
        bus(1'b0, 1'b0, 1'b0, 8'h00);
        check("R10 data unchanged", pad_out, 8'hA5);
        check("R10 dir unchanged", pad_oe, 8'hFF);

        // R9 same-cycle write and read
        bus(1'b1, 1'b1, 1'b1, 8'h00);
        check("R9 read returns pre-write", rdata, 8'hA5);
        check("R9 write took effect", pad_out, 8'h00);
        bus(1'b0, 1'b1, 1'b1, 8'h00);
        check("R9 next read new value", rdata, 8'h00);

        // R8 rdata holds without strobe
        bus(1'b1, 1'b0, 1'b1, 8'h3C);
        repeat (2) @(negedge clk);
        check("R8 rdata holds", rdata, 8'h00);

        // R6 synchroniser latency
        bus(1'b1, 1'b0, 1'b0, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hFF;
        @(negedge clk);
        rd_en = 1'b1; addr = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R6 read one edge early", rdata, 8'h00);
        bus(1'b0, 1'b1, 1'b1, 8'h00);
        check("R6 read after two edges", rdata, 8'hFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule